// File: doc/BRIEF.md
# Prioritized Interrupt and Bus-Request Arbiter

This block sits beside a small 8-bit processor core. It decides which of five asynchronous requests the core serves next. The requests are an external bus request, a non-maskable interrupt and three maskable interrupt lines. Every pin first passes through a multi-stage synchronizer. The non-maskable line and the two configurable maskable lines then go through edge or level qualification. A fixed priority picks one winner. The core marks its timing with two strobes: `cycle_end` closes each machine cycle, and `instr_end` closes each instruction and implies a machine-cycle end.

A bus request can be granted at any machine-cycle end. The grant is held for as long as the request stays active. Interrupts are granted only at an instruction end, as a one-cycle pulse:
- a non-maskable entry that carries the fixed entry address 0x0066, or
- a maskable acknowledge that carries a source code.

The acknowledge for the primary maskable line also raises two cycle qualifiers. These tell the rest of the system to supply a response vector. The block also holds a small trigger-mode register for the two secondary lines, and it shows their synchronized pin levels in a byte-wide port image.

Top module: `irq_bus_arbiter`

## Requirements
- R1: The synchronized levels of `int1_n` and `int2_n` appear on `port_levels` bit 6 and bit 7, SYNC_STAGES clocks after the pin changes (two at the default). All other bits of `port_levels` read 0.
- R2: When the synchronized `busreq_n` is low at a machine-cycle end, `bus_grant` rises on the next clock and stays high until the synchronized request goes high. While `bus_grant` is high, or while the request is active, no interrupt is granted.
- R3: A falling edge on `nmi_n` is latched as pending and is granted at the next instruction end whatever the interrupt-enable state. The grant pulses `nmi_take` for one clock with `nmi_vector` = 0x0066; `nmi_vector` is 0 at all other times. Further falling edges seen while the request is pending merge into that single grant.
- R4: A low `int0_n` is acknowledged at an instruction end only when the enable flag is set, no bus request is active and no NMI is pending. The acknowledge pulses `mi_ack` with `mi_src` = 0 and raises `ack_m1` and `ack_iorq` in the same clock.
- R5: `int1_n` and `int2_n` rank below `int0_n`, and INT1 beats INT2. Their acknowledges carry `mi_src` = 1 and 2 respectively and leave `ack_m1` and `ack_iorq` low.
- R6: `cfg_wdata` is written when `cfg_we` is high and reads back on `cfg_rdata`. Bits [1:0] set the INT1 trigger mode and bits [3:2] set the INT2 trigger mode: 0 = low level, 1 = rising edge, 2 = falling edge, 3 = low level. An edge seen in an edge mode stays pending until it is acknowledged.
- R7: The enable flag `ie_o` is set by an `ie_set` pulse. It is cleared in the same clock as any interrupt grant. No maskable acknowledge is issued while the flag is clear.
- R8: Interrupt grants happen only in the clock after an `instr_end` pulse, and at most one of `nmi_take` and `mi_ack` is high in any clock.
- R9: After reset all grant outputs are low, `ie_o` is 0, `cfg_rdata` is 0, and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busreq_n | input | 1 | Asynchronous bus request, active low |
| nmi_n | input | 1 | Asynchronous non-maskable interrupt, falling-edge |
| int0_n | input | 1 | Primary maskable interrupt, active-low level |
| int1_n | input | 1 | Secondary maskable interrupt 1, mode from cfg[1:0] |
| int2_n | input | 1 | Secondary maskable interrupt 2, mode from cfg[3:2] |
| cycle_end | input | 1 | Last clock of a machine cycle |
| instr_end | input | 1 | Last clock of an instruction (also a machine-cycle end) |
| ie_set | input | 1 | Sets the maskable enable flag |
| cfg_we | input | 1 | Trigger-mode register write strobe |
| cfg_wdata | input | 4 | Trigger-mode write data |
| cfg_rdata | output | 4 | Trigger-mode register contents |
| ie_o | output | 1 | Maskable enable flag |
| bus_grant | output | 1 | Bus handed to the external requester |
| nmi_take | output | 1 | One-clock NMI entry pulse |
| nmi_vector | output | 16 | 0x0066 during `nmi_take`, else 0 |
| mi_ack | output | 1 | One-clock maskable acknowledge pulse |
| mi_src | output | 2 | Acknowledged source: 0, 1 or 2 |
| ack_m1 | output | 1 | Opcode-fetch qualifier, INT0 acknowledge only |
| ack_iorq | output | 1 | I/O-request qualifier, INT0 acknowledge only |
| port_levels | output | 8 | Bit 6 = synced INT1 pin, bit 7 = synced INT2 pin |

## Verification
The hardest state to reach from the ports is a latched edge that waits unserved. Examples are an NMI with several merged edges, or a rising-edge INT2 that fired while the enable flag was clear. In both, the visible pin level no longer shows the request. The bench gets there by pulsing the pin back and forth and then letting many clocks pass with no boundary strobe or with the enable flag clear. It then shows that exactly one acknowledge follows and that a second boundary yields nothing. A second hard state is a bus grant still held while the request is being released. The bench samples there one clock after release, before the synchronizer has let the release through.

// File: rtl/irqarb_pkg.sv
// Package: shared constants and types for the interrupt/bus arbiter.
// Assumes the secondary maskable line count is fixed at two by the pin set.
package irqarb_pkg;

    // Secondary (mode-programmable) maskable lines
    localparam int NUM_EXT = 2;
    // Mode field width per line and total config width
    localparam int MODE_W  = 2;
    localparam int CFG_W   = NUM_EXT * MODE_W;
    // Source code width: INT0 plus the secondary lines
    localparam int SRC_W   = $clog2(NUM_EXT + 1);
    // Number of qualified lines: NMI plus secondary lines
    localparam int NUM_TRIG = NUM_EXT + 1;

    // Fixed non-maskable entry address
    localparam logic [15:0] NMI_ENTRY = 16'h0066;

    // Synchronized pin vector positions
    localparam int PIN_BREQ = 0;
    localparam int PIN_NMI  = 1;
    localparam int PIN_INT0 = 2;
    localparam int PIN_EXT0 = 3;
    localparam int NUM_PINS = PIN_EXT0 + NUM_EXT;

    // Trigger qualification mode
    typedef enum logic [MODE_W-1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_LOW2 = 2'd3
    } trig_mode_e;

endpackage

// File: rtl/irqarb_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// All stages reset to 1, which is the idle level of active-low pins, so
// no false edge appears after reset. Assumes STAGES >= 2.
module irqarb_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] lvl_o
);

    logic [STAGES-1:0][W-1:0] stg_q;

    // Shift pins through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '1;
        end else begin
            stg_q[0] <= pins_i;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign lvl_o = stg_q[STAGES-1];

endmodule

// File: rtl/irqarb_trig.sv
// Module: qualifies one synchronized active-low line as a request.
// Level modes report the current level. Edge modes latch the edge until
// clr_i acknowledges it. Assumes lvl_i is already synchronous.
module irqarb_trig
    import irqarb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  trig_mode_e mode_i,
    input  logic       clr_i,
    output logic       req_o
);

    logic prev_q;
    logic latch_q;
    logic is_edge;
    logic edge_hit;

    // Keep the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl_i;
    end

    // Decide whether the current mode is edge based and whether an edge hit
    always_comb begin
        is_edge  = (mode_i == TRIG_RISE) || (mode_i == TRIG_FALL);
        edge_hit = 1'b0;
        if (mode_i == TRIG_RISE) edge_hit = !prev_q && lvl_i;
        if (mode_i == TRIG_FALL) edge_hit = prev_q && !lvl_i;
    end

    // Hold a detected edge until acknowledged; merge repeats into one
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= 1'b0;
        else        latch_q <= is_edge && ((latch_q && !clr_i) || edge_hit);
    end

    assign req_o = is_edge ? latch_q : !lvl_i;

    AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && is_edge && !clr_i) |=> latch_q); // R6

endmodule

// File: rtl/irqarb_prio.sv
// Module: fixed-priority selector and grant registers.
// Priority: bus request, NMI, INT0, then the secondary lines by index.
// Assumes requests are synchronous and instr_end_i implies a cycle end.
module irqarb_prio
    import irqarb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               breq_i,
    input  logic               nmi_req_i,
    input  logic               int0_req_i,
    input  logic [NUM_EXT-1:0] ext_req_i,
    input  logic               cycle_end_i,
    input  logic               instr_end_i,
    input  logic               ie_set_i,
    output logic               nmi_clr_o,
    output logic [NUM_EXT-1:0] ext_clr_o,
    output logic               bus_grant_o,
    output logic               nmi_take_o,
    output logic               mi_ack_o,
    output logic [SRC_W-1:0]   mi_src_o,
    output logic               ack_m1_o,
    output logic               ack_iorq_o,
    output logic               ie_o
);

    logic             bg_q;
    logic             ie_q;
    logic             nmi_take_q;
    logic             mi_ack_q;
    logic [SRC_W-1:0] mi_src_q;
    logic             ack_m1_q;
    logic             ack_iorq_q;

    logic             irq_ok;
    logic             mask_ok;
    logic             take_nmi;
    logic             take_mi;
    logic [SRC_W-1:0] src_d;
    logic [NUM_EXT-1:0] ext_clr_d;

    // Pick the single interrupt winner at an instruction end
    always_comb begin
        irq_ok    = instr_end_i && !bg_q && !breq_i;
        take_nmi  = irq_ok && nmi_req_i;
        mask_ok   = irq_ok && !nmi_req_i && ie_q;
        take_mi   = 1'b0;
        src_d     = '0;
        ext_clr_d = '0;
        if (mask_ok && int0_req_i) begin
            take_mi = 1'b1;
        end else if (mask_ok) begin
            for (int i = 0; i < NUM_EXT; i++) begin
                if (!take_mi && ext_req_i[i]) begin
                    take_mi      = 1'b1;
                    src_d        = SRC_W'(i + 1);
                    ext_clr_d[i] = 1'b1;
                end
            end
        end
    end

    // Bus grant: taken at a machine-cycle end, held while requested
    always_ff @(posedge clk) begin
        if (!rst_n)    bg_q <= 1'b0;
        else if (bg_q) bg_q <= breq_i;
        else           bg_q <= breq_i && (cycle_end_i || instr_end_i);
    end

    // Enable flag: set by request, cleared by any interrupt grant
    always_ff @(posedge clk) begin
        if (!rst_n)                    ie_q <= 1'b0;
        else if (take_nmi || take_mi)  ie_q <= 1'b0;
        else if (ie_set_i)             ie_q <= 1'b1;
    end

    // Register the one-clock grant pulses and acknowledge qualifiers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_take_q <= 1'b0;
            mi_ack_q   <= 1'b0;
            mi_src_q   <= '0;
            ack_m1_q   <= 1'b0;
            ack_iorq_q <= 1'b0;
        end else begin
            nmi_take_q <= take_nmi;
            mi_ack_q   <= take_mi;
            mi_src_q   <= take_mi ? src_d : '0;
            ack_m1_q   <= take_mi && (src_d == '0);
            ack_iorq_q <= take_mi && (src_d == '0);
        end
    end

    assign nmi_clr_o   = take_nmi;
    assign ext_clr_o   = ext_clr_d;
    assign bus_grant_o = bg_q;
    assign nmi_take_o  = nmi_take_q;
    assign mi_ack_o    = mi_ack_q;
    assign mi_src_o    = mi_src_q;
    assign ack_m1_o    = ack_m1_q;
    assign ack_iorq_o  = ack_iorq_q;
    assign ie_o        = ie_q;

    AST_BUS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        bg_q |=> (!nmi_take_q && !mi_ack_q)); // R2
    AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req_i && !take_nmi) |=> nmi_req_i); // R3
    AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        mi_ack_q |-> !$past(nmi_req_i)); // R4
    AST_INT0_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        ack_m1_q |-> (mi_ack_q && ack_iorq_q && mi_src_q == '0)); // R4
    AST_EXT_NO_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mi_ack_q && mi_src_q != '0) |-> (!ack_m1_q && !ack_iorq_q)); // R5
    AST_IE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_take_q || mi_ack_q) |-> !ie_q); // R7
    AST_MI_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        mi_ack_q |-> $past(ie_q)); // R7
    AST_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_take_q || mi_ack_q) |-> $past(instr_end_i)); // R8
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nmi_take_q, mi_ack_q})); // R8

endmodule

// File: rtl/irq_bus_arbiter.sv
// Module: top of the interrupt and bus-request arbiter.
// Synchronizes the pins, qualifies NMI and the secondary lines, holds the
// trigger-mode register and drives the grant outputs.
// Assumes the core pulses cycle_end/instr_end for one clock each.
module irq_bus_arbiter
    import irqarb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busreq_n,
    input  logic             nmi_n,
    input  logic             int0_n,
    input  logic             int1_n,
    input  logic             int2_n,
    input  logic             cycle_end,
    input  logic             instr_end,
    input  logic             ie_set,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             ie_o,
    output logic             bus_grant,
    output logic             nmi_take,
    output logic [15:0]      nmi_vector,
    output logic             mi_ack,
    output logic [SRC_W-1:0] mi_src,
    output logic             ack_m1,
    output logic             ack_iorq,
    output logic [7:0]       port_levels
);

    logic [NUM_PINS-1:0] lvl;
    logic [CFG_W-1:0]    cfg_q;
    logic [NUM_TRIG-1:0] trig_req;
    logic [NUM_TRIG-1:0] trig_clr;
    logic                nmi_clr;
    logic [NUM_EXT-1:0]  ext_clr;

    irqarb_sync #(
        .W      (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({int2_n, int1_n, int0_n, nmi_n, busreq_n}),
        .lvl_o  (lvl)
    );

    // Trigger-mode register write
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    assign trig_clr = {ext_clr, nmi_clr};

    // One qualifier per edge-capable line: slot 0 is NMI, fixed to falling
    generate
        for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
            trig_mode_e mode;
            if (t == 0) begin : g_nmi
                assign mode = TRIG_FALL;
            end else begin : g_ext
                assign mode = trig_mode_e'(cfg_q[(t-1)*MODE_W +: MODE_W]);
            end
            irqarb_trig trig_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (lvl[PIN_NMI + (t == 0 ? 0 : PIN_EXT0 - 1 + t - 1)]),
                .mode_i (mode),
                .clr_i  (trig_clr[t]),
                .req_o  (trig_req[t])
            );
        end
    endgenerate

    irqarb_prio prio_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .breq_i      (!lvl[PIN_BREQ]),
        .nmi_req_i   (trig_req[0]),
        .int0_req_i  (!lvl[PIN_INT0]),
        .ext_req_i   (trig_req[NUM_TRIG-1:1]),
        .cycle_end_i (cycle_end),
        .instr_end_i (instr_end),
        .ie_set_i    (ie_set),
        .nmi_clr_o   (nmi_clr),
        .ext_clr_o   (ext_clr),
        .bus_grant_o (bus_grant),
        .nmi_take_o  (nmi_take),
        .mi_ack_o    (mi_ack),
        .mi_src_o    (mi_src),
        .ack_m1_o    (ack_m1),
        .ack_iorq_o  (ack_iorq),
        .ie_o        (ie_o)
    );

    assign cfg_rdata   = cfg_q;
    assign nmi_vector  = nmi_take ? NMI_ENTRY : 16'h0000;
    assign port_levels = {lvl[PIN_EXT0+1], lvl[PIN_EXT0], 6'b000000};

    AST_VECTOR_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_take |-> (nmi_vector == 16'h0000)); // R3
    AST_PORT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        port_levels[5:0] == 6'b000000); // R1

endmodule

// File: tb/irq_bus_arbiter_tb_top.sv
module irq_bus_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busreq_n = 1'b1, nmi_n = 1'b1, int0_n = 1'b1, int1_n = 1'b1, int2_n = 1'b1;
    logic       cycle_end = 1'b0, instr_end = 1'b0, ie_set = 1'b0, cfg_we = 1'b0;
    logic [3:0] cfg_wdata = 4'h0;
    logic [3:0] cfg_rdata;
    logic       ie_o, bus_grant, nmi_take, mi_ack, ack_m1, ack_iorq;
    logic [15:0] nmi_vector;
    logic [1:0] mi_src;
    logic [7:0] port_levels;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_bus_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .busreq_n(busreq_n), .nmi_n(nmi_n),
        .int0_n(int0_n), .int1_n(int1_n), .int2_n(int2_n),
        .cycle_end(cycle_end), .instr_end(instr_end), .ie_set(ie_set),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ie_o(ie_o), .bus_grant(bus_grant), .nmi_take(nmi_take),
        .nmi_vector(nmi_vector), .mi_ack(mi_ack), .mi_src(mi_src),
        .ack_m1(ack_m1), .ack_iorq(ack_iorq), .port_levels(port_levels)
    );

    // Vector: cfg[18:15] pins_a[14:10] pins_b[9:5] ie[4] kind[3:2] src[1:0]
    // pins order {busreq, nmi, int0, int1, int2}; kind 0 none,1 nmi,2 mi,3 bus
    localparam int NV = 13;
    localparam logic [18:0] VECS [NV] = '{
        {4'h0, 5'b11111, 5'b11011, 1'b1, 2'd2, 2'd0},  // R4 int0 level
        {4'h0, 5'b11111, 5'b11011, 1'b0, 2'd0, 2'd0},  // R7 masked
        {4'h0, 5'b11111, 5'b10111, 1'b0, 2'd1, 2'd0},  // R3 nmi with ie clear
        {4'h0, 5'b11111, 5'b10011, 1'b1, 2'd1, 2'd0},  // R3 nmi over int0
        {4'h0, 5'b11111, 5'b00111, 1'b1, 2'd3, 2'd0},  // R2 bus over nmi
        {4'h0, 5'b11111, 5'b11100, 1'b1, 2'd2, 2'd1},  // R5 int1 over int2
        {4'h0, 5'b11111, 5'b11110, 1'b1, 2'd2, 2'd2},  // R5 int2 alone
        {4'h0, 5'b11111, 5'b11001, 1'b1, 2'd2, 2'd0},  // R5 int0 over int1
        {4'h1, 5'b11101, 5'b11111, 1'b1, 2'd2, 2'd1},  // R6 int1 rising
        {4'h1, 5'b11111, 5'b11101, 1'b1, 2'd0, 2'd0},  // R6 int1 rising, fall only
        {4'h8, 5'b11111, 5'b11110, 1'b1, 2'd2, 2'd2},  // R6 int2 falling
        {4'h4, 5'b11110, 5'b11110, 1'b1, 2'd0, 2'd0},  // R6 int2 rising, held low
        {4'h3, 5'b11111, 5'b11101, 1'b1, 2'd2, 2'd1}   // R6 int1 mode 3 = level
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(input logic [4:0] p);
        {busreq_n, nmi_n, int0_n, int1_n, int2_n} = p;
    endtask

    task automatic do_reset();
        pins(5'b11111);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic boundary();
        instr_end = 1'b1; cycle_end = 1'b1;
        tick(1);
        instr_end = 1'b0; cycle_end = 1'b0;
    endtask

    task automatic pulse_ie();
        ie_set = 1'b1; tick(1); ie_set = 1'b0;
    endtask

    task automatic write_cfg(input logic [3:0] v);
        cfg_wdata = v; cfg_we = 1'b1; tick(1); cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R8: watchdog expired, actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(1);
        do_reset();
        // R9 reset state
        chk("R9 bus_grant", bus_grant, 0);
        chk("R9 nmi_take", nmi_take, 0);
        chk("R9 mi_ack", mi_ack, 0);
        chk("R9 ie_o", ie_o, 0);
        chk("R9 cfg_rdata", cfg_rdata, 0);
        boundary();
        chk("R9 nothing pending", {nmi_take, mi_ack}, 0);
        chk("R1 idle port", port_levels, 8'hC0);

        // R1 synchronizer latency on bits 6/7
        int1_n = 1'b0;
        tick(1);
        chk("R1 int1 one clock", port_levels, 8'hC0);
        tick(1);
        chk("R1 int1 two clocks", port_levels, 8'h80);
        int2_n = 1'b0;
        tick(2);
        chk("R1 int2 two clocks", port_levels, 8'h00);

        // R6 config readback
        write_cfg(4'b1001);
        chk("R6 cfg readback", cfg_rdata, 4'b1001);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [18:0] e;
            logic [1:0] kind;
            e = VECS[v];
            do_reset();
            write_cfg(e[18:15]);
            pins(e[14:10]);
            tick(4);
            if (e[4]) pulse_ie();
            pins(e[9:5]);
            tick(5);
            boundary();
            kind = bus_grant ? 2'd3 : nmi_take ? 2'd1 : mi_ack ? 2'd2 : 2'd0;
            chk($sformatf("R2/R3/R4/R5/R6 vector %0d kind", v), kind, e[3:2]);
            if (e[3:2] == 2'd2) begin
                chk($sformatf("R5 vector %0d src", v), mi_src, e[1:0]);
                chk($sformatf("R4/R5 vector %0d strobes", v), {ack_m1, ack_iorq},
                    (e[1:0] == 2'd0) ? 2'b11 : 2'b00);
            end
            if (e[3:2] == 2'd1) chk($sformatf("R3 vector %0d entry", v), nmi_vector, 16'h0066);
        end

        // R3 merged NMI edges give one grant; R8 no grant without boundary
        do_reset();
        nmi_n = 1'b0; tick(3); nmi_n = 1'b1; tick(3); nmi_n = 1'b0; tick(3); nmi_n = 1'b1;
        tick(20);
        chk("R8 no grant without instr_end", {nmi_take, mi_ack}, 0);
        chk("R3 vector idle zero", nmi_vector, 16'h0000);
        boundary();
        chk("R3 merged nmi take", nmi_take, 1);
        chk("R3 nmi entry", nmi_vector, 16'h0066);
        tick(1);
        chk("R8 take is one clock", nmi_take, 0);
        boundary();
        chk("R3 merged edges one grant", nmi_take, 0);

        // R7 enable auto-clear and re-enable
        do_reset();
        pulse_ie();
        chk("R7 ie set", ie_o, 1);
        int0_n = 1'b0; tick(4);
        boundary();
        chk("R4 int0 ack", {mi_ack, mi_src}, {1'b1, 2'd0});
        chk("R7 ie cleared on grant", ie_o, 0);
        tick(1);
        boundary();
        chk("R7 no ack with ie clear", mi_ack, 0);
        pulse_ie();
        boundary();
        chk("R7 ack after re-enable", mi_ack, 1);

        // R2 bus grant at cycle end, hold, block and release
        do_reset();
        pulse_ie();
        int0_n = 1'b0; busreq_n = 1'b0; tick(4);
        chk("R2 no grant before cycle end", bus_grant, 0);
        cycle_end = 1'b1; tick(1); cycle_end = 1'b0;
        chk("R2 grant at cycle end", bus_grant, 1);
        boundary();
        chk("R2 interrupts blocked", mi_ack, 0);
        chk("R2 grant held", bus_grant, 1);
        busreq_n = 1'b1;
        tick(1);
        chk("R2 grant held during release sync", bus_grant, 1);
        tick(3);
        chk("R2 grant released", bus_grant, 0);
        boundary();
        chk("R2 int0 after release", {mi_ack, mi_src}, {1'b1, 2'd0});

        // R6 rising edge held while masked, one grant only
        do_reset();
        write_cfg(4'b0100);
        int2_n = 1'b0; tick(4); int2_n = 1'b1; tick(4);
        boundary();
        chk("R6 masked edge no ack", mi_ack, 0);
        tick(10);
        pulse_ie();
        boundary();
        chk("R6 held edge acked", {mi_ack, mi_src}, {1'b1, 2'd2});
        chk("R5 int2 no strobes", {ack_m1, ack_iorq}, 2'b00);
        tick(1);
        pulse_ie();
        boundary();
        chk("R6 edge cleared after ack", mi_ack, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule